// File: doc/BRIEF.md
# Iterative Interruptible Divider

This block divides a 32-bit or 16-bit numerator by a 16-bit denominator and returns a 16-bit quotient and a 16-bit remainder. Operands may be treated as unsigned or two's-complement signed, in integer or fractional (Q1.15 result) form. It uses restoring division on operand magnitudes and resolves one quotient bit per clock. Every operation takes exactly 19 busy cycles: one setup cycle, sixteen iteration cycles, one sign-correction cycle and one writeback cycle.

A `hold` input freezes the whole operation in whatever cycle it is in. Each held cycle lengthens the operation by one cycle and leaves the final result unchanged. A surrounding sequencer can therefore suspend the divide, for example to service another request, and resume it later.

The controller has five states: `ST_IDLE`, `ST_SETUP`, `ST_ITER`, `ST_FIX` and `ST_WRITE`.

- `ST_IDLE` goes to `ST_SETUP` when `start` is sampled high.
- `ST_SETUP` goes to `ST_ITER`.
- `ST_ITER` stays in place for sixteen cycles and then goes to `ST_FIX`.
- `ST_FIX` goes to `ST_WRITE`.
- `ST_WRITE` returns to `ST_IDLE` and raises `done`.
- While `hold` is high in any state other than `ST_IDLE`, the controller keeps its current state.

Top module: `iter_divider`

## Requirements
- R1: After reset, `busy`, `done`, `ovf`, `quotient` and `remainder` are all zero.
- R2: When `start` is sampled high in idle, `busy` is high for exactly 19 cycles (with no hold). `done` is high for one cycle in the first cycle in which `busy` is low again.
- R3: With `wide`=0, `sgn`=0 and `frac`=0, the numerator is `dividend[15:0]` zero-extended, and the outputs are floor(N/D) and N mod D.
- R4: With `wide`=1 and `sgn`=0, the numerator is the full 32-bit `dividend`.
- R5: With `sgn`=1, the numerator is `dividend[15:0]` sign-extended (`wide`=0) or `dividend[31:0]` (`wide`=1), and the divisor is signed. The quotient truncates toward zero, and the remainder takes the sign of the numerator.
- R6: With `frac`=1 and `wide`=0, the divided magnitude is |`dividend[15:0]`| multiplied by 2^15, so the quotient is in Q1.15.
- R7: With `frac`=1 and `wide`=1, the divided magnitude is |`dividend`| shifted right by one bit.
- R8: `ovf` is high with `done` when the divisor is zero or the quotient does not fit. The unsigned range is 0..65535 and the signed range is -32768..32767. `quotient` and `remainder` are not specified in that case.
- R9: While `hold` is high during an operation, all progress stops and `busy` stays high. Each held cycle adds one busy cycle, and the result is unchanged.
- R10: `start` and operand changes while `busy` is high have no effect on the running operation or its result.
- R11: `quotient`, `remainder` and `ovf` change only when an operation completes and keep their values after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| hold | input | 1 | Freeze a running operation |
| wide | input | 1 | 1: 32-bit numerator, 0: 16-bit numerator |
| sgn | input | 1 | Signed operands |
| frac | input | 1 | Fractional alignment |
| dividend | input | 32 | Numerator |
| divisor | input | 16 | Denominator |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 16 | Quotient result |
| remainder | output | 16 | Remainder result |
| ovf | output | 1 | Divide-by-zero or quotient range overflow |

## Verification
The assertions assume three things about the inputs: `hold` is driven only to pause a running operation, operands are captured only on the start cycle, and `start` is a clean level sampled on the clock edge. The assertions check freezing under `hold`, the shape of the `done` pulse, immunity to `start` while busy, and the zero-divisor flag. The bench changes every input one half-cycle away from the rising edge. It raises `hold` at chosen busy-cycle offsets (setup, mid-iteration, writeback) and always lowers it before the operation would end. It also re-pulses `start` with altered operands mid-operation to probe the ignore behaviour.

// File: rtl/div_pkg.sv
package div_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ITER,
        ST_FIX,
        ST_WRITE
    } div_state_t;

    typedef struct packed {
        logic wide;
        logic sgn;
        logic frac;
    } div_mode_t;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
    import div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2*W-1:0] num,
    input  logic [W-1:0]   den,
    input  div_mode_t      mode,
    output logic [2*W-1:0] num_aligned,
    output logic [W-1:0]   den_mag,
    output logic           neg_q,
    output logic           neg_r,
    output logic           pre_ovf
);
    localparam int NW = 2 * W;

    logic [NW-1:0] ext;
    logic [NW-1:0] mag;
    logic          sn;
    logic          sd;

    always_comb begin
        if (mode.wide) begin
            ext = num;
        end else if (mode.sgn) begin
            ext = {{W{num[W-1]}}, num[W-1:0]};
        end else begin
            ext = {{W{1'b0}}, num[W-1:0]};
        end
        sn  = mode.sgn & ext[NW-1];
        mag = sn ? (~ext + 1'b1) : ext;

        if (!mode.frac) begin
            num_aligned = mag;
        end else if (mode.wide) begin
            num_aligned = mag >> 1;
        end else begin
            num_aligned = mag << (W - 1);
        end

        sd      = mode.sgn & den[W-1];
        den_mag = sd ? (~den + 1'b1) : den;
        neg_q   = sn ^ sd;
        neg_r   = sn;
        pre_ovf = (den_mag == '0) || (num_aligned[NW-1:W] >= den_mag);
    end
endmodule

// File: rtl/div_step.sv
module div_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] lo_in,
    input  logic [W-1:0] den,
    output logic [W-1:0] rem_out,
    output logic [W-1:0] lo_out
);
    logic [W:0] trial;
    logic [W:0] diff;
    logic       take;

    always_comb begin
        trial   = {rem_in, lo_in[W-1]};
        diff    = trial - {1'b0, den};
        take    = trial >= {1'b0, den};
        rem_out = take ? diff[W-1:0] : trial[W-1:0];
        lo_out  = {lo_in[W-2:0], take};
    end
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
    parameter int W = 16
) (
    input  logic [W-1:0] q_mag,
    input  logic [W-1:0] r_mag,
    input  logic         neg_q,
    input  logic         neg_r,
    input  logic         sgn,
    output logic [W-1:0] q_out,
    output logic [W-1:0] r_out,
    output logic         range_ovf
);
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        q_out = neg_q ? (~q_mag + 1'b1) : q_mag;
        r_out = neg_r ? (~r_mag + 1'b1) : r_mag;
        if (!sgn) begin
            range_ovf = 1'b0;
        end else if (neg_q) begin
            range_ovf = q_mag > HALF;
        end else begin
            range_ovf = q_mag[W-1];
        end
    end
endmodule

// File: rtl/iter_divider.sv
module iter_divider
    import div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             hold,
    input  logic             wide,
    input  logic             sgn,
    input  logic             frac,
    input  logic [2*W-1:0]   dividend,
    input  logic [W-1:0]     divisor,
    output logic             busy,
    output logic             done,
    output logic [W-1:0]     quotient,
    output logic [W-1:0]     remainder,
    output logic             ovf
);
    localparam int NW = 2 * W;
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    div_state_t state, state_nx;

    logic [NW-1:0] op_num;
    logic [W-1:0]  op_den;
    div_mode_t     op_mode;

    logic [CW-1:0] cnt;
    logic [W-1:0]  p_rem;
    logic [W-1:0]  p_lo;
    logic [W-1:0]  d_mag;
    logic          f_neg_q, f_neg_r, f_pre_ovf;
    logic [W-1:0]  res_q, res_r;
    logic          res_ovf;
    logic [W-1:0]  out_q, out_r;
    logic          out_ovf;
    logic          done_r;

    logic [NW-1:0] pr_num;
    logic [W-1:0]  pr_den;
    logic          pr_neg_q, pr_neg_r, pr_ovf;
    logic [W-1:0]  st_rem, st_lo;
    logic [W-1:0]  fx_q, fx_r;
    logic          fx_ovf;
    logic          run;

    div_operand_prep #(.W(W)) u_prep (
        .num(op_num), .den(op_den), .mode(op_mode),
        .num_aligned(pr_num), .den_mag(pr_den),
        .neg_q(pr_neg_q), .neg_r(pr_neg_r), .pre_ovf(pr_ovf)
    );

    div_step #(.W(W)) u_step (
        .rem_in(p_rem), .lo_in(p_lo), .den(d_mag),
        .rem_out(st_rem), .lo_out(st_lo)
    );

    div_sign_fix #(.W(W)) u_fix (
        .q_mag(p_lo), .r_mag(p_rem), .neg_q(f_neg_q), .neg_r(f_neg_r),
        .sgn(op_mode.sgn), .q_out(fx_q), .r_out(fx_r), .range_ovf(fx_ovf)
    );

    assign run = (state != ST_IDLE) && !hold;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_SETUP;
            ST_SETUP: if (!hold) state_nx = ST_ITER;
            ST_ITER:  if (!hold && cnt == LAST) state_nx = ST_FIX;
            ST_FIX:   if (!hold) state_nx = ST_WRITE;
            ST_WRITE: if (!hold) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_num <= '0; op_den <= '0; op_mode <= '0;
            cnt <= '0; p_rem <= '0; p_lo <= '0; d_mag <= '0;
            f_neg_q <= 1'b0; f_neg_r <= 1'b0; f_pre_ovf <= 1'b0;
            res_q <= '0; res_r <= '0; res_ovf <= 1'b0;
            out_q <= '0; out_r <= '0; out_ovf <= 1'b0;
            done_r <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (state == ST_IDLE) begin
                if (start) begin
                    op_num  <= dividend;
                    op_den  <= divisor;
                    op_mode <= '{wide: wide, sgn: sgn, frac: frac};
                end
            end else if (run) begin
                unique case (state)
                    ST_SETUP: begin
                        p_rem     <= pr_num[NW-1:W];
                        p_lo      <= pr_num[W-1:0];
                        d_mag     <= pr_den;
                        f_neg_q   <= pr_neg_q;
                        f_neg_r   <= pr_neg_r;
                        f_pre_ovf <= pr_ovf;
                        cnt       <= '0;
                    end
                    ST_ITER: begin
                        p_rem <= st_rem;
                        p_lo  <= st_lo;
                        cnt   <= cnt + 1'b1;
                    end
                    ST_FIX: begin
                        res_q   <= fx_q;
                        res_r   <= fx_r;
                        res_ovf <= f_pre_ovf | fx_ovf;
                    end
                    ST_WRITE: begin
                        out_q   <= res_q;
                        out_r   <= res_r;
                        out_ovf <= res_ovf;
                        done_r  <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = done_r;
        quotient  = out_q;
        remainder = out_r;
        ovf       = out_ovf;
    end

    assert_hold_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hold) |=> (busy && $stable(cnt) && $stable(p_rem) && $stable(p_lo) && $stable(state)));

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_busy_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_ignore_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(op_num) && $stable(op_den) && $stable(op_mode)));

    assert_zero_div_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_den == '0) |-> ovf);

    assert_outputs_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == ST_WRITE && !hold) |=> ($stable(quotient) && $stable(remainder) && $stable(ovf)));
endmodule

// File: tb/tb_iter_divider.sv
`timescale 1ns/1ps
module tb_iter_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, hold = 1'b0, wide = 1'b0, sgn = 1'b0, frac = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        busy, done, ovf;
    logic [15:0] quotient, remainder;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    iter_divider dut (
        .clk(clk), .rst_n(rst_n), .start(start), .hold(hold),
        .wide(wide), .sgn(sgn), .frac(frac),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .quotient(quotient),
        .remainder(remainder), .ovf(ovf)
    );

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic void ref_div(input bit lg, input bit sg, input bit fr,
                                    input logic [31:0] n, input logic [15:0] d,
                                    output logic [15:0] eq, output logic [15:0] er, output bit eo);
        longint ext, mag, nal, dm, qm, rm;
        bit sn, sd;
        if (lg) ext = sg ? longint'($signed(n)) : longint'(n);
        else    ext = sg ? longint'($signed(n[15:0])) : longint'(n[15:0]);
        sn  = ext < 0;
        mag = sn ? -ext : ext;
        nal = fr ? (lg ? (mag >> 1) : (mag << 15)) : mag;
        dm  = sg ? longint'($signed(d)) : longint'(d);
        sd  = dm < 0;
        if (sd) dm = -dm;
        eq = '0; er = '0;
        if (dm == 0) begin
            eo = 1'b1;
            return;
        end
        qm = nal / dm;
        rm = nal % dm;
        eo = (qm > 65535) || (sg && ((sn ^ sd) ? (qm > 32768) : (qm > 32767)));
        eq = (sn ^ sd) ? 16'(-qm) : 16'(qm);
        er = sn ? 16'(-rm) : 16'(rm);
    endfunction

    task automatic do_div(input string tag, input bit lg, input bit sg, input bit fr,
                          input logic [31:0] n, input logic [15:0] d,
                          input int hold_at, input int hold_len, input bit poke);
        logic [15:0] eq, er;
        bit eo;
        int cyc;
        ref_div(lg, sg, fr, n, d, eq, er, eo);
        @(negedge clk);
        wide = lg; sgn = sg; frac = fr; dividend = n; divisor = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (busy && cyc < 200) begin
            cyc++;
            if (cyc == hold_at) hold = 1'b1;
            if (cyc == hold_at + hold_len) hold = 1'b0;
            if (poke && cyc == 4) begin
                start = 1'b1; dividend = ~n; divisor = d + 16'd3; sgn = ~sg; wide = ~lg;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        hold = 1'b0;
        check(tag, "R2 busy cycles", cyc, 19 + hold_len);
        check(tag, "R2 done pulse", done, 1);
        check(tag, "R8 ovf", ovf, eo);
        if (!eo) begin
            check(tag, "quotient", quotient, eq);
            check(tag, "remainder", remainder, er);
        end
        @(negedge clk);
        check(tag, "R2 done low after one cycle", done, 0);
        if (!eo) check(tag, "R11 quotient kept", quotient, eq);
    endtask

    task automatic test_reset();
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "ovf", ovf, 0);
        check("R1", "quotient", quotient, 0);
        check("R1", "remainder", remainder, 0);
    endtask

    task automatic test_unsigned_short();
        do_div("R3", 0, 0, 0, 32'd1000, 16'd7, 0, 0, 0);
        do_div("R3", 0, 0, 0, 32'h0000FFFF, 16'd1, 0, 0, 0);
        do_div("R3", 0, 0, 0, 32'hABCD0005, 16'd9, 0, 0, 0);
    endtask

    task automatic test_unsigned_long();
        do_div("R4", 1, 0, 0, 32'h00123456, 16'h1234, 0, 0, 0);
        do_div("R4", 1, 0, 0, 32'hFFFE0001, 16'hFFFF, 0, 0, 0);
    endtask

    task automatic test_signed();
        do_div("R5", 0, 1, 0, 32'h0000FFF9, 16'd2, 0, 0, 0);
        do_div("R5", 0, 1, 0, 32'd7, 16'hFFFE, 0, 0, 0);
        do_div("R5", 1, 1, 0, 32'hFFFE7960, 16'd300, 0, 0, 0);
    endtask

    task automatic test_frac_short();
        do_div("R6", 0, 0, 1, 32'h00004000, 16'h8000, 0, 0, 0);
        do_div("R6", 0, 1, 1, 32'h0000C000, 16'h4000, 0, 0, 0);
        do_div("R6", 0, 1, 1, 32'h00002000, 16'h6000, 0, 0, 0);
    endtask

    task automatic test_frac_long();
        do_div("R7", 1, 1, 1, 32'h20000000, 16'h4000, 0, 0, 0);
        do_div("R7", 1, 0, 1, 32'h12345679, 16'h7001, 0, 0, 0);
    endtask

    task automatic test_overflow();
        do_div("R8", 0, 0, 0, 32'd55, 16'd0, 0, 0, 0);
        do_div("R8", 1, 0, 0, 32'h00050000, 16'd5, 0, 0, 0);
        do_div("R8", 0, 1, 0, 32'h00008000, 16'hFFFF, 0, 0, 0);
    endtask

    task automatic test_hold();
        do_div("R9", 1, 0, 0, 32'h00ABCDEF, 16'h0F0F, 1, 3, 0);
        do_div("R9", 0, 1, 0, 32'h0000F00D, 16'd17, 10, 5, 0);
        do_div("R9", 1, 1, 1, 32'hE0000001, 16'h3FFF, 19, 2, 0);
    endtask

    task automatic test_start_ignored();
        do_div("R10", 0, 0, 0, 32'd60000, 16'd13, 0, 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_unsigned_short();
        test_unsigned_long();
        test_signed();
        test_frac_short();
        test_frac_long();
        test_overflow();
        test_hold();
        test_start_ignored();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule